// File: doc/BRIEF.md
# ARINC 429 Receive Word Acceptance Filter

This block sits behind the bit-level receive logic of an ARINC 429 channel. When the receive logic signals that a full 32-bit word has been assembled, the filter captures the word. It decides whether to keep the word, using two independently enabled checks. The first compares the 8-bit label against a small programmable table. The second compares the two source/destination bits against a configured pair. A kept word is written into a 32-entry receive FIFO, with its top bit replaced by a parity-error flag. A rejected word leaves no trace.

Control is a three-state machine. In `ST_IDLE` the block waits for the end-of-word strobe and captures the word (transition *capture*). In `ST_EVAL` it forms the verdict. From there it either moves to `ST_STORE` (transition *accept*) or returns to `ST_IDLE` (transition *discard*, taken for a failed check or for a full FIFO). In `ST_STORE` it pushes the word and returns to `ST_IDLE` (transition *commit*). The host drains the FIFO through a show-ahead read port and watches its data-ready, half-full and full flags.

Top module: `a429_word_filter`

## Requirements
- R1: A word is taken only on a cycle where `eos` is high in `ST_IDLE`. An accepted word makes `data_ready` rise at the second rising edge after the edge that samples `eos`. Changing `word_in` without `eos` stores nothing.
- R2: Bit numbering runs from ARINC bit 1 = `word_in[0]` to bit 32 = `word_in[31]`. If the 32 received bits have odd parity, the stored word has bit 31 cleared and bits 30:0 unchanged.
- R3: If the 32 received bits have even parity, the stored word has bit 31 set and bits 30:0 unchanged, and the word is still stored.
- R4: With `lbl_chk_en` high, a word is dropped when `word_in[7:0]` equals none of the active table entries.
- R5: Only table entries with an index below `tbl_count` are active. An entry at a higher index never produces a match.
- R6: With `sd_chk_en` high, a word is dropped unless `word_in[8]` equals `sd_ref[0]` and `word_in[9]` equals `sd_ref[1]`.
- R7: With both checks disabled, every word is stored. With both enabled, a word is stored only when both pass. With one enabled, only that check decides. Parity never causes a drop.
- R8: A table entry is written on the rising edge where `tbl_wr_en` is high, at index `tbl_wr_idx`. It takes effect for the next word.
- R9: Stored words leave the FIFO in arrival order. `rd_data` shows the oldest word, and `rd_en` high with `data_ready` high removes it at the rising edge.
- R10: `data_ready` is high when at least 1 word is held. `half_full` is high when at least 16 are held. `full` is high when 32 are held.
- R11: With the FIFO full, a word that passes its checks is dropped, and the 32 stored words are read out unchanged.
- R12: After reset the FIFO is empty, all three flags are low, the machine is in `ST_IDLE`, and every table entry is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | 32 | Assembled ARINC word, bit 1 in bit 0 |
| eos | input | 1 | End-of-word strobe, one cycle |
| lbl_chk_en | input | 1 | Enable label table check |
| sd_chk_en | input | 1 | Enable source/destination bit check |
| sd_ref | input | 2 | Expected bits 10 and 9 |
| tbl_wr_en | input | 1 | Label table write strobe |
| tbl_wr_idx | input | 4 | Label table write index |
| tbl_wr_lbl | input | 8 | Label value to write |
| tbl_count | input | 5 | Number of active table entries, 0 to 16 |
| rd_en | input | 1 | Pop the oldest FIFO word |
| rd_data | output | 32 | Oldest FIFO word, show-ahead |
| data_ready | output | 1 | FIFO not empty |
| half_full | output | 1 | FIFO holds 16 or more words |
| full | output | 1 | FIFO holds 32 words |

## Verification
A machine stuck outside `ST_IDLE` stops all storage: the next accepted word never raises `data_ready`. A machine that skips `ST_EVAL` changes the two-edge latency, and this shows within three cycles of the strobe. A wrong label or source/destination verdict appears as a missing word, or an unexpected extra word, at the next read. A bad FIFO pointer or count shows as misordered or corrupt read data, or as flags that disagree with the number of words written. Both show up by the time the FIFO is drained after a fill to 32.

// File: rtl/a429_filt_pkg.sv
package a429_filt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_STORE = 2'd2
    } filt_state_t;

    localparam int A429_BITS = 32;
    localparam int LBL_BITS  = 8;

    // Replace bit 32 with the parity-error flag: 0 for odd parity, 1 for even.
    function automatic logic [A429_BITS-1:0] mark_parity(input logic [A429_BITS-1:0] w);
        return {~(^w), w[A429_BITS-2:0]};
    endfunction

endpackage

// File: rtl/a429_label_table.sv
module a429_label_table #(
    parameter int SLOTS = 16,
    parameter int LW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(SLOTS)-1:0]   wr_idx,
    input  logic [LW-1:0]              wr_lbl,
    input  logic [$clog2(SLOTS):0]     use_cnt,
    input  logic [LW-1:0]              probe,
    output logic                       hit
);
    localparam int IW = $clog2(SLOTS);
    localparam int CW = IW + 1;

    logic [LW-1:0]    entry [SLOTS];
    logic [SLOTS-1:0] slot_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) entry[i] <= '0;
        end else if (wr_en) begin
            entry[wr_idx] <= wr_lbl;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot_hit[g] = (CW'(g) < use_cnt) && (entry[g] == probe);
    end

    assign hit = |slot_hit;

    assert_tbl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> entry[$past(wr_idx)] == $past(wr_lbl));

endmodule

// File: rtl/a429_rx_fifo.sv
module a429_rx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         data_ready,
    output logic         half_full,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          wr_ok, rd_ok;

    assign wr_ok = push && (cnt != FULL_CNT);
    assign rd_ok = pop && (cnt != '0);

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + AW'(1);
            if (rd_ok) rptr <= rptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata      = mem[rptr];
    assign data_ready = (cnt != '0);
    assign half_full  = (cnt >= HALF_CNT);
    assign full       = (cnt == FULL_CNT);

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
    assert_flags_nest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half_full && data_ready));
    assert_full_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(rdata)));

endmodule

// File: rtl/a429_accept_fsm.sv
module a429_accept_fsm
    import a429_filt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eos,
    input  logic [A429_BITS-1:0] word_in,
    input  logic                 lbl_chk_en,
    input  logic                 sd_chk_en,
    input  logic [1:0]           sd_ref,
    input  logic                 lbl_hit,
    input  logic                 fifo_full,
    output logic [LBL_BITS-1:0]  probe_lbl,
    output logic                 push,
    output logic [A429_BITS-1:0] push_data
);
    filt_state_t          state, state_nx;
    logic [A429_BITS-1:0] held;
    logic                 sd_ok, verdict;

    assign sd_ok   = (held[9:8] == sd_ref);
    assign verdict = (!lbl_chk_en || lbl_hit) && (!sd_chk_en || sd_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            held  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && eos) held <= word_in;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (eos) state_nx = ST_EVAL;
            ST_EVAL:  state_nx = (verdict && !fifo_full) ? ST_STORE : ST_IDLE;
            ST_STORE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        probe_lbl = held[LBL_BITS-1:0];
        push_data = mark_parity(held);
        push      = (state == ST_STORE);
    end

    assert_store_after_eos_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(eos, 2));
    assert_eval_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL) |=> (state != ST_EVAL));
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL && fifo_full) |=> !push);

endmodule

// File: rtl/a429_word_filter.sv
module a429_word_filter
    import a429_filt_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int LBL_SLOTS  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [31:0]                  word_in,
    input  logic                         eos,
    input  logic                         lbl_chk_en,
    input  logic                         sd_chk_en,
    input  logic [1:0]                   sd_ref,
    input  logic                         tbl_wr_en,
    input  logic [$clog2(LBL_SLOTS)-1:0] tbl_wr_idx,
    input  logic [7:0]                   tbl_wr_lbl,
    input  logic [$clog2(LBL_SLOTS):0]   tbl_count,
    input  logic                         rd_en,
    output logic [31:0]                  rd_data,
    output logic                         data_ready,
    output logic                         half_full,
    output logic                         full
);
    logic [LBL_BITS-1:0]  probe_lbl;
    logic                 lbl_hit;
    logic                 push;
    logic [A429_BITS-1:0] push_data;

    a429_label_table #(.SLOTS(LBL_SLOTS), .LW(LBL_BITS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_lbl(tbl_wr_lbl),
        .use_cnt(tbl_count), .probe(probe_lbl), .hit(lbl_hit)
    );

    a429_accept_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .eos(eos), .word_in(word_in),
        .lbl_chk_en(lbl_chk_en), .sd_chk_en(sd_chk_en), .sd_ref(sd_ref),
        .lbl_hit(lbl_hit), .fifo_full(full),
        .probe_lbl(probe_lbl), .push(push), .push_data(push_data)
    );

    a429_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(A429_BITS)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata(push_data), .pop(rd_en), .rdata(rd_data),
        .data_ready(data_ready), .half_full(half_full), .full(full)
    );

endmodule

// File: tb/test_a429_word_filter.sv
module test_a429_word_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] word_in = '0;
    logic        eos = 1'b0;
    logic        lbl_chk_en = 1'b0, sd_chk_en = 1'b0;
    logic [1:0]  sd_ref = 2'b00;
    logic        tbl_wr_en = 1'b0;
    logic [3:0]  tbl_wr_idx = '0;
    logic [7:0]  tbl_wr_lbl = '0;
    logic [4:0]  tbl_count = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        data_ready, half_full, full;

    int checks = 0, fails = 0;
    bit hold = 1'b0, done = 1'b0;
    logic [31:0] expq[$];

    always #10 clk = ~clk;

    a429_word_filter i_a429_word_filter (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .eos(eos),
        .lbl_chk_en(lbl_chk_en), .sd_chk_en(sd_chk_en), .sd_ref(sd_ref),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_lbl(tbl_wr_lbl),
        .tbl_count(tbl_count), .rd_en(rd_en), .rd_data(rd_data),
        .data_ready(data_ready), .half_full(half_full), .full(full)
    );

    function automatic logic [31:0] stored(input logic [31:0] w);
        return {~(^w), w[30:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && !hold && data_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R9 unexpected stored word (R4 R5 R6 R7)", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(rd_data == e, "R9 order / R2 R3 bit32", rd_data, e);
            end
            rd_en <= 1'b1;
        end else begin
            rd_en <= 1'b0;
        end
    end

    // Driver: strobe one word; queue its stored form if expected to be kept.
    task automatic send(input logic [31:0] w, input bit keep);
        @(negedge clk);
        word_in = w;
        eos = 1'b1;
        if (keep) expq.push_back(stored(w));
        @(negedge clk);
        eos = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic tbl_write(input logic [3:0] idx, input logic [7:0] lbl);
        @(negedge clk);
        tbl_wr_en = 1'b1;
        tbl_wr_idx = idx;
        tbl_wr_lbl = lbl;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 200 && expq.size() != 0; k++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, tag, 32'(expq.size()), 32'h0);
        chk(data_ready == 1'b0, tag, 32'(data_ready), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(data_ready == 1'b0, "R12 data_ready after reset", 32'(data_ready), 0);
        chk(half_full == 1'b0, "R12 half_full after reset", 32'(half_full), 0);
        chk(full == 1'b0, "R12 full after reset", 32'(full), 0);

        // R12 table cleared: one active entry, value 00, label 00 matches
        lbl_chk_en = 1'b1;
        tbl_count = 5'd1;
        send(32'h1234_5600, 1'b1);
        send(32'h1234_5601, 1'b0);
        drain("R12 cleared table entry");
        lbl_chk_en = 1'b0;

        // R1 latency and strobe-only capture
        hold = 1'b1;
        @(negedge clk);
        word_in = 32'h0000_0001;
        eos = 1'b1;
        expq.push_back(stored(32'h0000_0001));
        @(negedge clk);
        eos = 1'b0;
        chk(data_ready == 1'b0, "R1 one edge after eos", 32'(data_ready), 0);
        @(negedge clk);
        chk(data_ready == 1'b0, "R1 two edges after eos", 32'(data_ready), 0);
        @(negedge clk);
        chk(data_ready == 1'b1, "R1 stored after eval edge", 32'(data_ready), 1);
        hold = 1'b0;
        drain("R1 drain");
        word_in = 32'hDEAD_BEEF;
        repeat (6) @(negedge clk);
        chk(data_ready == 1'b0, "R1 no eos no store", 32'(data_ready), 0);

        // R2 R3 R7 both checks off: parity patterns, all stored
        send(32'h0000_0007, 1'b1);   // odd
        send(32'h0000_0003, 1'b1);   // even
        send(32'hFFFF_FFFF, 1'b1);   // even, top set
        send(32'h8000_0000, 1'b1);   // odd, top set -> cleared
        drain("R7 both disabled accept all");

        // R4 R5 R8 label table
        tbl_write(4'd0, 8'h31);
        tbl_write(4'd1, 8'hA5);
        tbl_write(4'd5, 8'h77);
        tbl_count = 5'd2;
        lbl_chk_en = 1'b1;
        send(32'h0ABC_0031, 1'b1);
        send(32'h0ABC_00A5, 1'b1);
        send(32'h0ABC_0077, 1'b0);  // R5 index 5 inactive
        send(32'h0ABC_0012, 1'b0);  // R4 no match
        drain("R4 R5 R8 label filter");
        tbl_count = 5'd6;
        send(32'h0ABC_0077, 1'b1);  // R5 now active
        drain("R5 widened count");

        // R6 source/destination only
        lbl_chk_en = 1'b0;
        sd_chk_en = 1'b1;
        sd_ref = 2'b10;
        send(32'h0000_0212, 1'b1);
        send(32'h0000_0112, 1'b0);
        send(32'h0000_0312, 1'b0);
        drain("R6 sd filter");

        // R7 both enabled
        lbl_chk_en = 1'b1;
        send(32'h0000_0231, 1'b1);
        send(32'h0000_0131, 1'b0);
        send(32'h0000_0212, 1'b0);
        drain("R7 both enabled");
        lbl_chk_en = 1'b0;
        sd_chk_en = 1'b0;

        // R10 R11 fill to full, overflow drop, ordered drain (R9)
        hold = 1'b1;
        for (int i = 0; i < 32; i++) begin
            send(32'h5000_0000 + 32'(i * 32'h0001_0101), 1'b1);
            if (i == 14) chk(half_full == 1'b0, "R10 half_full at 15", 32'(half_full), 0);
            if (i == 15) chk(half_full == 1'b1, "R10 half_full at 16", 32'(half_full), 1);
            if (i == 30) chk(full == 1'b0, "R10 full at 31", 32'(full), 0);
        end
        chk(full == 1'b1, "R10 full at 32", 32'(full), 1);
        send(32'h7777_7777, 1'b0);
        chk(full == 1'b1, "R11 still full after drop", 32'(full), 1);
        chk(rd_data == stored(32'h5000_0000), "R11 head unchanged", rd_data, stored(32'h5000_0000));
        hold = 1'b0;
        drain("R11 R9 drain after overflow");
        chk(half_full == 1'b0, "R10 half_full empty", 32'(half_full), 0);

        finish_run();
    end

endmodule